// File: doc/BRIEF.md
# Run-Length Test Data Decompressor

This block sits between a low-cost tester and the scan-in pin of a core under test. The tester stores its patterns in a frequency-directed run-length code and sends the compressed stream to the block one bit at a time. The block rebuilds the original stream, which is a sequence of runs of 0s, each closed by a single 1. In this code a short run gets a short codeword. A codeword of group k holds 2k bits. The first k bits are a unary group selector: (k-1) ones and then a 0. The next k bits are a binary offset within the group.

Both sides share one clock. The tester side uses a valid/ready handshake. The scan side supplies a shift strobe, and the block emits at most one decoded bit for each strobe. A parameter sets the widest group that the block accepts. A selector that is too long stops the block with a sticky fault, which only reset clears. A second parameter decides how the block behaves while the offset bits are still arriving. In one setting it already shifts out the zeros that every run of the group must contain. In the other it waits until the whole offset is in.

Top module: `rld_decomp`

## Requirements
- R1: While reset is active, and in the first cycle after it, `cw_ready` is 1, and `scan_shift`, `scan_data` and `fault` are 0.
- R2: A selector of (k-1) ones followed by a 0 chooses group k. The next k accepted bits form the offset, most significant bit first. The run length is (2^k - 2) + offset, so for example "01" decodes to run 1, "110000" to run 6, "1001" to run 3 and "110010" to run 8.
- R3: Each decoded run appears on `scan_data` as exactly that many 0s and then one 1, one bit for each emission, with runs in stream order. The 18-bit stream for runs 1, 6, 3, 8 yields the 22-bit output 0 1 000000 1 000 1 00000000 1.
- R4: `scan_shift` is 1 only in the cycle after a clock edge at which `shift_stb` was 1. `scan_data` keeps its value in every cycle in which `scan_shift` is 0.
- R5: `cw_ready` is 0 from the edge that accepts the last offset bit until the edge that emits the terminating 1. A bit offered in that window is taken only after the run completes.
- R6: With OVERLAP=1 the block emits the 2^k - 2 zeros that every run of the group contains while it still waits for offset bits, and it keeps `cw_ready` at 1 during that time.
- R7: KMAX consecutive selector ones set `fault`. The fault stays set until reset. While it is set, `cw_ready` is 0 and `scan_shift` stays 0. After reset the block decodes normally again.
- R8: The extreme groups decode correctly. "00" gives a run of 0, which is a lone 1. Group KMAX with an all-ones offset gives 2^(KMAX+1) - 3 zeros.
- R9: While `shift_stb` is low, the block emits nothing and loses no decoding progress. Once the strobe comes back, the pending run comes out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the tester and scan sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_valid | input | 1 | Tester offers a compressed bit |
| cw_bit | input | 1 | Compressed bit value |
| cw_ready | output | 1 | Block takes the offered bit on this edge |
| shift_stb | input | 1 | Scan side allows one emission on this edge |
| scan_data | output | 1 | Decoded scan-in bit |
| scan_shift | output | 1 | Scan chain shift enable for the current `scan_data` |
| fault | output | 1 | Sticky over-long selector flag |

## Verification
The hardest condition to reach from the ports is the overlap window. Here the selector is complete but the offset is not, and the block is already emitting the group's base zeros. With the tester sending at full rate, this window lasts only k cycles. The bench therefore holds `cw_valid` low after a group-3 selector while the strobe runs. It counts exactly six zeros, checks that `cw_ready` stays high, and then delivers the offset and checks the rest of the run. Back-pressure is reached by offering the next codeword right after a long run's last offset bit. The fault is reached with a stream of KMAX ones.

// File: rtl/rld_pkg.sv
package rld_pkg;

   typedef enum logic [1:0] {
      ST_SEL  = 2'd0,
      ST_OFS  = 2'd1,
      ST_RUN  = 2'd2,
      ST_HALT = 2'd3
   } rld_state_e;

endpackage

// File: rtl/rld_sel_ctr.sv
module rld_sel_ctr #(
   parameter int KMAX = 8,
   localparam int GW = $clog2(KMAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   output logic [GW-1:0] cnt,
   output logic          full
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + GW'(1);
   end

   assign full = (cnt == GW'(KMAX - 1));

endmodule

// File: rtl/rld_ofs_reg.sv
module rld_ofs_reg #(
   parameter int KMAX = 8,
   localparam int GW = $clog2(KMAX + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [GW-1:0]   len,
   input  logic            shift,
   input  logic            bit_in,
   output logic [KMAX-1:0] value,
   output logic            last
);

   logic [GW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
         left  <= '0;
      end else if (load) begin
         value <= '0;
         left  <= len;
      end else if (shift) begin
         value <= {value[KMAX-2:0], bit_in};
         left  <= left - GW'(1);
      end
   end

   assign last = (left == GW'(1));

endmodule

// File: rtl/rld_zero_ctr.sv
module rld_zero_ctr #(
   parameter int CW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          add,
   input  logic [CW-1:0] add_val,
   input  logic          dec,
   output logic          is_zero
);

   logic [CW-1:0] cnt;
   logic [CW-1:0] base_v;
   logic [CW-1:0] nxt;

   always_comb begin
      base_v = load ? load_val : cnt;
      nxt    = base_v + (add ? add_val : '0) - (dec ? CW'(1) : '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= nxt;
   end

   assign is_zero = (cnt == '0);

endmodule

// File: rtl/rld_decomp.sv
module rld_decomp #(
   parameter int KMAX    = 8,
   parameter bit OVERLAP = 1'b1,
   localparam int GW = $clog2(KMAX + 1),
   localparam int CW = KMAX + 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cw_valid,
   input  logic cw_bit,
   output logic cw_ready,
   input  logic shift_stb,
   output logic scan_data,
   output logic scan_shift,
   output logic fault
);
   import rld_pkg::*;

   initial begin
      if (KMAX < 2 || KMAX > 15) $error("rld_decomp: KMAX must lie in 2..15");
   end

   rld_state_e      state, state_nx;
   logic            take, take_one, take_zero, in_sel, in_ofs;
   logic            sel_full, ofs_last, zc_zero, ovl_ok;
   logic            emit_zero, emit_one, ofs_done, overflow;
   logic [GW-1:0]   sel_cnt, grp;
   logic [CW-1:0]   grp_base, ofs_full;
   logic [KMAX-1:0] ofs_val;

   generate
      if (OVERLAP) begin : g_overlap
         assign ovl_ok = 1'b1;
      end else begin : g_serial
         assign ovl_ok = 1'b0;
      end
   endgenerate

   assign in_sel    = (state == ST_SEL);
   assign in_ofs    = (state == ST_OFS);
   assign cw_ready  = in_sel || in_ofs;
   assign take      = cw_valid && cw_ready;
   assign take_one  = take && in_sel && cw_bit;
   assign take_zero = take && in_sel && !cw_bit;
   assign overflow  = take_one && sel_full;
   assign ofs_done  = take && in_ofs && ofs_last;

   assign grp      = sel_cnt + GW'(1);
   assign grp_base = (CW'(1) << grp) - CW'(2);
   assign ofs_full = CW'({ofs_val[KMAX-2:0], cw_bit});

   assign emit_zero = shift_stb && !zc_zero &&
                      ((in_ofs && ovl_ok) || state == ST_RUN);
   assign emit_one  = shift_stb && zc_zero && state == ST_RUN;

   rld_sel_ctr #(.KMAX(KMAX)) u_sel (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (take_zero),
      .inc   (take_one && !sel_full),
      .cnt   (sel_cnt),
      .full  (sel_full)
   );

   rld_ofs_reg #(.KMAX(KMAX)) u_ofs (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (take_zero),
      .len    (grp),
      .shift  (take && in_ofs),
      .bit_in (cw_bit),
      .value  (ofs_val),
      .last   (ofs_last)
   );

   rld_zero_ctr #(.CW(CW)) u_zero (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (take_zero),
      .load_val (grp_base),
      .add      (ofs_done),
      .add_val  (ofs_full),
      .dec      (emit_zero),
      .is_zero  (zc_zero)
   );

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_SEL: begin
            if (overflow)       state_nx = ST_HALT;
            else if (take_zero) state_nx = ST_OFS;
         end
         ST_OFS:  if (ofs_done) state_nx = ST_RUN;
         ST_RUN:  if (emit_one) state_nx = ST_SEL;
         default: state_nx = ST_HALT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_SEL;
         scan_shift <= 1'b0;
         scan_data  <= 1'b0;
      end else begin
         state      <= state_nx;
         scan_shift <= emit_zero || emit_one;
         if (emit_zero || emit_one) scan_data <= emit_one;
      end
   end

   assign fault = (state == ST_HALT);

endmodule

// File: rtl/rld_decomp_chk.sv
module rld_decomp_chk (
   input logic clk,
   input logic rst_n,
   input logic cw_ready,
   input logic shift_stb,
   input logic scan_data,
   input logic scan_shift,
   input logic fault
);

   assert_halt_no_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !cw_ready);

   assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> fault);

   assert_halt_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !scan_shift);

   assert_shift_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      scan_shift |-> $past(shift_stb));

   assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_shift |-> $stable(scan_data));

endmodule

bind rld_decomp rld_decomp_chk u_rld_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cw_ready   (cw_ready),
   .shift_stb  (shift_stb),
   .scan_data  (scan_data),
   .scan_shift (scan_shift),
   .fault      (fault)
);

// File: tb/rld_decomp_bench.sv
module rld_decomp_bench;
   localparam int CLK_PERIOD = 10;
   localparam int KMAX = 8;

   logic clk = 1'b0;
   logic rst_n, cw_valid, cw_bit, shift_stb;
   logic cw_ready, scan_data, scan_shift, fault;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic stream_q[$];
   logic exp_q[$];
   logic got_q[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   rld_decomp #(.KMAX(KMAX), .OVERLAP(1'b1)) u_rld_decomp (
      .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .cw_bit(cw_bit),
      .cw_ready(cw_ready), .shift_stb(shift_stb), .scan_data(scan_data),
      .scan_shift(scan_shift), .fault(fault)
   );

   always @(negedge clk) if (rst_n && scan_shift) got_q.push_back(scan_data);

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic encode_run(input int len);
      int k = 1;
      int ofs;
      while (len > (1 << (k + 1)) - 3) k++;
      for (int i = 0; i < k - 1; i++) stream_q.push_back(1'b1);
      stream_q.push_back(1'b0);
      ofs = len - ((1 << k) - 2);
      for (int i = k - 1; i >= 0; i--) stream_q.push_back(ofs[i]);
      for (int i = 0; i < len; i++) exp_q.push_back(1'b0);
      exp_q.push_back(1'b1);
   endtask

   task automatic send_bit(input logic b);
      cw_valid = 1'b1;
      cw_bit   = b;
      while (!cw_ready) @(negedge clk);
      @(negedge clk);
      cw_valid = 1'b0;
   endtask

   task automatic drain();
      repeat (600) @(negedge clk);
   endtask

   task automatic compare_out(input string req);
      int bad = -1;
      check(got_q.size() == exp_q.size(), {req, " length"}, got_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
         if (bad < 0 && got_q[i] !== exp_q[i]) bad = i;
      check(bad < 0, {req, " first mismatching bit index"}, bad, -1);
   endtask

   task automatic run_list(input int runs[], input string req);
      stream_q.delete(); exp_q.delete(); got_q.delete();
      foreach (runs[i]) encode_run(runs[i]);
      foreach (stream_q[i]) send_bit(stream_q[i]);
      drain();
      compare_out(req);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; cw_valid = 1'b0; cw_bit = 1'b0; shift_stb = 1'b0;
      repeat (3) @(negedge clk);
      check(cw_ready === 1'b1, "R1 ready in reset", cw_ready, 1);
      check(scan_shift === 1'b0 && scan_data === 1'b0, "R1 scan outputs in reset",
            {scan_shift, scan_data}, 0);
      check(fault === 1'b0, "R1 fault in reset", fault, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(cw_ready === 1'b1 && scan_shift === 1'b0 && fault === 1'b0,
            "R1 state after reset", {cw_ready, scan_shift, fault}, 4);
   endtask

   task automatic t_example();
      stream_q.delete(); exp_q.delete();
      encode_run(1); encode_run(6); encode_run(3); encode_run(8);
      check(stream_q.size() == 18, "R2 compressed length", stream_q.size(), 18);
      check(exp_q.size() == 22, "R3 expanded length", exp_q.size(), 22);
      shift_stb = 1'b1;
      run_list('{1, 6, 3, 8}, "R3 example stream");
   endtask

   task automatic t_mixed();
      shift_stb = 1'b1;
      run_list('{0, 2, 5, 13, 14, 29, 61, 200}, "R2 mixed groups");
      run_list('{0, 0, 509}, "R8 extreme groups");
   endtask

   task automatic t_overlap();
      int zeros = 0;
      stream_q.delete(); exp_q.delete(); got_q.delete();
      shift_stb = 1'b1;
      send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
      repeat (20) @(negedge clk);
      foreach (got_q[i]) if (got_q[i] === 1'b0) zeros++;
      check(got_q.size() == 6 && zeros == 6, "R6 base zeros before offset", got_q.size(), 6);
      check(cw_ready === 1'b1, "R6 ready while waiting for offset", cw_ready, 1);
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
      drain();
      for (int i = 0; i < 9; i++) exp_q.push_back(1'b0);
      exp_q.push_back(1'b1);
      compare_out("R6 overlapped run 9");
   endtask

   task automatic t_backpressure();
      stream_q.delete(); exp_q.delete(); got_q.delete();
      shift_stb = 1'b1;
      encode_run(100);
      foreach (stream_q[i]) send_bit(stream_q[i]);
      check(cw_ready === 1'b0, "R5 ready low after last offset bit", cw_ready, 0);
      encode_run(0);
      send_bit(1'b0); send_bit(1'b0);
      drain();
      compare_out("R5 run then queued codeword");
      check(cw_ready === 1'b1, "R5 ready back after run", cw_ready, 1);
   endtask

   task automatic t_stall();
      logic held;
      stream_q.delete(); exp_q.delete(); got_q.delete();
      shift_stb = 1'b0;
      held = scan_data;
      encode_run(3);
      foreach (stream_q[i]) send_bit(stream_q[i]);
      repeat (10) @(negedge clk);
      check(got_q.size() == 0, "R9 nothing emitted without strobe", got_q.size(), 0);
      check(scan_data === held, "R4 scan_data held without strobe", scan_data, held);
      for (int i = 0; i < 40; i++) begin
         shift_stb = ~shift_stb;
         @(negedge clk);
      end
      shift_stb = 1'b1;
      drain();
      compare_out("R9 run after stall");
   endtask

   task automatic t_fault();
      shift_stb = 1'b1;
      for (int i = 0; i < KMAX; i++) send_bit(1'b1);
      check(fault === 1'b1, "R7 fault after KMAX ones", fault, 1);
      check(cw_ready === 1'b0, "R7 ready low in fault", cw_ready, 0);
      got_q.delete();
      cw_valid = 1'b1; cw_bit = 1'b0;
      repeat (10) @(negedge clk);
      cw_valid = 1'b0;
      check(got_q.size() == 0 && fault === 1'b1, "R7 fault sticky and silent",
            got_q.size(), 0);
      do_reset();
      check(fault === 1'b0, "R7 fault cleared by reset", fault, 0);
      shift_stb = 1'b1;
      run_list('{4, 1}, "R7 decode after reset");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      t_example();
      t_mixed();
      t_overlap();
      t_backpressure();
      t_stall();
      t_fault();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule